// File: doc/BRIEF.md
# Segment-Synchronised Tape Mode Sequencer

This block governs the operating mode of a tape formatter. The formatter's timing repeats in a cycle of four equal time segments, numbered 0 to 3. A host asks for one of three modes: play, record of main and auxiliary data, or record of auxiliary data only. The sequencer first checks that the change is allowed. It then holds the request until the segment boundary that belongs to that particular transition, and commits the change there.

After a commit into a record mode, the write enables rise only after a fixed number of segment events, so that tape writing starts at the beginning of a segment 1. A commit back into play drops the write enables on the same clock edge. Leaving full recording also forces the segment counter back to 0 and raises a resynchronisation flag for a fixed number of segments. The segment length is a parameter in clock cycles.

Top module: `tape_mode_seq`

## Requirements
- R1: After a synchronous active-low reset the block is in play (mode code 0) in segment 0. Both write enables, the resync flag and the error bit are low.
- R2: Each segment lasts SEG_CYCLES clock cycles. The segment output steps 0, 1, 2, 3, 0 on the last cycle of each segment, except where R11 applies.
- R3: Mode codes are 0 = play, 1 = record main+aux, 2 = record aux only. A request is ignored and sets the sticky error bit when it carries code 3, names the mode already in effect, or moves directly between the two record modes. Asserting err_clr clears the bit, but a new illegal request in the same cycle leaves it set.
- R4: A legal request is held as pending from the next cycle and replaces any earlier pending request. Its legality is judged against the mode that will be in effect after the current clock edge, so a request in a commit cycle is checked against the newly committed mode.
- R5: Play to record main+aux commits at the first segment end whose cycle follows the request cycle. A request made in the last cycle of a segment therefore commits at the end of the following segment.
- R6: Play to record aux only commits at the first end of segment 2 after the request.
- R7: Either record mode changes to play at the first end of segment 0 after the request.
- R8: After a commit into record main+aux, wr_main and wr_aux both rise at the first end of segment 0 that follows MAIN_LEAD (default 2) ends of segment 3 counted strictly after the commit.
- R9: After a commit into record aux only, wr_aux alone rises at the first end of segment 0 that follows AUX_LEAD (default 1) end of segment 3 after the commit.
- R10: On a commit into play, both write enables are low from that edge on, and any start of writing that had not yet happened is cancelled.
- R11: When record main+aux commits to play, the segment counter goes to 0 instead of 1.
- R12: On the record main+aux to play commit, the resync flag rises on the commit edge. It stays high for exactly RESYNC_SEGS (default 5) segments and falls on the RESYNC_SEGS-th following segment end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host mode request strobe |
| req_mode | input | 2 | Requested mode code |
| err_clr | input | 1 | Clears the sticky error bit |
| mode | output | 2 | Committed mode code |
| seg | output | 2 | Current time segment |
| wr_main | output | 1 | Main data write enable |
| wr_aux | output | 1 | Auxiliary data write enable |
| resync | output | 1 | Resynchronisation pending flag |
| req_err | output | 1 | Sticky illegal-request flag |

## Verification
Two events can fall in the same cycle: a host request and the commit of an earlier pending request at its segment boundary. The bench waits for the last cycle of segment 0 while a return to play is pending. In that cycle it issues a record request that is illegal against the old mode but legal against the new one. The request must be held as pending and must then commit. In a second collision, an illegal request arrives together with err_clr, and the error bit must stay set. A behavioural reference model compares every output on every clock.

// File: rtl/tms_pkg.sv
// Package: shared mode encoding and the transition legality rule for the
// tape mode sequencer. Assumes mode code 3 is never a valid mode.
package tms_pkg;

    typedef enum logic [1:0] {
        TM_PLAY     = 2'd0,
        TM_REC_FULL = 2'd1,
        TM_REC_AUX  = 2'd2,
        TM_BAD      = 2'd3
    } tm_mode_e;

    // True when moving from cur to nxt is a permitted transition.
    function automatic logic tm_step_ok(input tm_mode_e cur, input tm_mode_e nxt);
        logic ok;
        ok = 1'b0;
        if (nxt != TM_BAD && nxt != cur) begin
            ok = (cur == TM_PLAY) || (nxt == TM_PLAY);
        end
        return ok;
    endfunction

endpackage

// File: rtl/tms_seg_timer.sv
// Segment timer: counts SEG_CYCLES clocks per segment and steps a 2-bit
// segment index. A force_zero request, valid only on a segment end,
// sends the index to 0 instead of advancing it.
// Assumes SEG_CYCLES >= 2.
module tms_seg_timer #(
    parameter int SEG_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       force_zero,
    output logic [1:0] seg_o,
    output logic       seg_end_o
);
    localparam int CW = (SEG_CYCLES > 2) ? $clog2(SEG_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SEG_CYCLES - 1);

    logic [CW-1:0] cyc_q;
    logic [1:0]    seg_q;

    // Marks the last cycle of the current segment.
    assign seg_end_o = (cyc_q == LAST);
    assign seg_o     = seg_q;

    // Cycle counter inside a segment.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc_q <= '0;
        else if (seg_end_o)  cyc_q <= '0;
        else                 cyc_q <= cyc_q + 1'b1;
    end

    // Segment index, advanced or forced to zero at each segment end.
    always_ff @(posedge clk) begin
        if (!rst_n)                       seg_q <= 2'd0;
        else if (seg_end_o && force_zero) seg_q <= 2'd0;
        else if (seg_end_o)               seg_q <= seg_q + 2'd1;
    end

    // R2: normal step on a segment end
    a_r2_seg_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_end_o && !force_zero) |=> (seg_q == $past(seg_q) + 2'd1));
    // R2: segment index holds between ends
    a_r2_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_end_o |=> $stable(seg_q));
    // R11: forced return to segment 0
    a_r11_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_end_o && force_zero) |=> (seg_q == 2'd0));

endmodule

// File: rtl/tms_req_latch.sv
// Request latch: screens host requests against the mode that will be in
// effect after this edge, keeps the newest legal one as pending until it
// commits, and keeps a sticky error bit for rejected requests.
// Assumes commit is only raised while a request is pending.
module tms_req_latch
    import tms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       err_clr,
    input  tm_mode_e   mode_next,
    input  logic       commit,
    output logic       pend_valid_o,
    output tm_mode_e   pend_mode_o,
    output logic       err_o
);
    logic     legal;
    logic     reject;
    tm_mode_e req_e;
    logic     pend_valid_q;
    tm_mode_e pend_mode_q;
    logic     err_q;

    // Classify the incoming request.
    always_comb begin
        req_e  = tm_mode_e'(req_mode);
        legal  = req_valid && tm_step_ok(mode_next, req_e);
        reject = req_valid && !legal;
    end

    // Pending request: newest legal request wins, a commit consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid_q <= 1'b0;
            pend_mode_q  <= TM_PLAY;
        end else if (legal) begin
            pend_valid_q <= 1'b1;
            pend_mode_q  <= req_e;
        end else if (commit) begin
            pend_valid_q <= 1'b0;
        end
    end

    // Sticky error bit: setting has priority over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (reject)  err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    assign pend_valid_o = pend_valid_q;
    assign pend_mode_o  = pend_mode_q;
    assign err_o        = err_q;

    // R3: code 3 is always rejected
    a_r3_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd3) |=> err_q);
    // R3: error bit survives without a clear
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);
    // R4: a pending request never holds an invalid code
    a_r4_pend_valid_code: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_q |-> (pend_mode_q != TM_BAD));

endmodule

// File: rtl/tms_commit_ctl.sv
// Commit controller: decides at which segment end a pending request takes
// effect, holds the committed mode, delays the write enables by counted
// segment events and times the resync flag.
// Assumes seg_end is high for exactly one cycle per segment.
module tms_commit_ctl
    import tms_pkg::*;
#(
    parameter int MAIN_LEAD   = 2,
    parameter int AUX_LEAD    = 1,
    parameter int RESYNC_SEGS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] seg,
    input  logic       seg_end,
    input  logic       pend_valid,
    input  tm_mode_e   pend_mode,
    output logic       commit_o,
    output tm_mode_e   mode_next_o,
    output tm_mode_e   mode_o,
    output logic       force_zero_o,
    output logic       wr_main_o,
    output logic       wr_aux_o,
    output logic       resync_o
);
    localparam int LEAD_MAX = (MAIN_LEAD > AUX_LEAD) ? MAIN_LEAD : AUX_LEAD;
    localparam int EW       = $clog2(LEAD_MAX + 1) + 1;
    localparam int RW       = $clog2(RESYNC_SEGS + 1) + 1;

    tm_mode_e      mode_q;
    logic          wait_q;
    logic [EW-1:0] ev_q;
    logic [EW-1:0] need;
    logic          wr_main_q;
    logic          wr_aux_q;
    logic [RW-1:0] rs_q;
    logic          at_bound;

    // Boundary rule per transition.
    always_comb begin
        at_bound = 1'b0;
        case (mode_q)
            TM_PLAY: begin
                if (pend_mode == TM_REC_FULL)     at_bound = 1'b1;
                else if (pend_mode == TM_REC_AUX) at_bound = (seg == 2'd2);
            end
            TM_REC_FULL, TM_REC_AUX: at_bound = (pend_mode == TM_PLAY) && (seg == 2'd0);
            default: at_bound = 1'b0;
        endcase
    end

    // Commit strobe, next mode and forced segment reset.
    always_comb begin
        commit_o     = pend_valid && seg_end && at_bound;
        mode_next_o  = commit_o ? pend_mode : mode_q;
        force_zero_o = commit_o && (mode_q == TM_REC_FULL);
        need         = (mode_q == TM_REC_FULL) ? EW'(MAIN_LEAD) : EW'(AUX_LEAD);
    end

    // Mode register, delayed write start and immediate write stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= TM_PLAY;
            wait_q    <= 1'b0;
            ev_q      <= '0;
            wr_main_q <= 1'b0;
            wr_aux_q  <= 1'b0;
        end else if (commit_o) begin
            mode_q <= pend_mode;
            ev_q   <= '0;
            if (pend_mode == TM_PLAY) begin
                wait_q    <= 1'b0;
                wr_main_q <= 1'b0;
                wr_aux_q  <= 1'b0;
            end else begin
                wait_q <= 1'b1;
            end
        end else if (wait_q && seg_end) begin
            if (seg == 2'd3 && ev_q < need) begin
                ev_q <= ev_q + 1'b1;
            end
            if (seg == 2'd0 && ev_q >= need) begin
                wait_q    <= 1'b0;
                wr_aux_q  <= 1'b1;
                wr_main_q <= (mode_q == TM_REC_FULL);
            end
        end
    end

    // Resync window counted in segment ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rs_q <= '0;
        else if (force_zero_o)             rs_q <= RW'(RESYNC_SEGS);
        else if (seg_end && rs_q != '0)    rs_q <= rs_q - 1'b1;
    end

    assign mode_o    = mode_q;
    assign wr_main_o = wr_main_q;
    assign wr_aux_o  = wr_aux_q;
    assign resync_o  = (rs_q != '0);

    // R7: a change into play only happens at the end of segment 0
    a_r7_play_at_seg0: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_PLAY && $past(mode_q) != TM_PLAY) |-> ($past(seg) == 2'd0 && $past(seg_end)));
    // R6: play to aux-only only at the end of segment 2
    a_r6_aux_at_seg2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_REC_AUX && $past(mode_q) == TM_PLAY) |-> ($past(seg) == 2'd2 && $past(seg_end)));
    // R10: in play no write enable is high
    a_r10_no_write_in_play: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_PLAY) |-> (!wr_main_q && !wr_aux_q));
    // R8: main writing only in full record mode
    a_r8_main_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_main_q |-> (mode_q == TM_REC_FULL && wr_aux_q));
    // R9: writing starts only at the start of segment 1
    a_r9_start_at_seg1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_aux_q) |-> (seg == 2'd1));
    // R12: resync rises only on leaving full record mode
    a_r12_resync_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resync_o) |-> ($past(mode_q) == TM_REC_FULL && mode_q == TM_PLAY));

endmodule

// File: rtl/tape_mode_seq.sv
// Top: tape mode sequencer. Joins the segment timer, request latch and
// commit controller. Assumes the host holds req_valid for one cycle per
// request and that SEG_CYCLES >= 2.
module tape_mode_seq #(
    parameter int SEG_CYCLES  = 8,
    parameter int MAIN_LEAD   = 2,
    parameter int AUX_LEAD    = 1,
    parameter int RESYNC_SEGS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       err_clr,
    output logic [1:0] mode,
    output logic [1:0] seg,
    output logic       wr_main,
    output logic       wr_aux,
    output logic       resync,
    output logic       req_err
);
    import tms_pkg::*;

    logic     seg_end;
    logic     force_zero;
    logic     commit;
    logic     pend_valid;
    tm_mode_e pend_mode;
    tm_mode_e mode_next;
    tm_mode_e mode_cur;

    tms_seg_timer #(.SEG_CYCLES(SEG_CYCLES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_zero (force_zero),
        .seg_o      (seg),
        .seg_end_o  (seg_end)
    );

    tms_req_latch u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_mode     (req_mode),
        .err_clr      (err_clr),
        .mode_next    (mode_next),
        .commit       (commit),
        .pend_valid_o (pend_valid),
        .pend_mode_o  (pend_mode),
        .err_o        (req_err)
    );

    tms_commit_ctl #(
        .MAIN_LEAD   (MAIN_LEAD),
        .AUX_LEAD    (AUX_LEAD),
        .RESYNC_SEGS (RESYNC_SEGS)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .seg          (seg),
        .seg_end      (seg_end),
        .pend_valid   (pend_valid),
        .pend_mode    (pend_mode),
        .commit_o     (commit),
        .mode_next_o  (mode_next),
        .mode_o       (mode_cur),
        .force_zero_o (force_zero),
        .wr_main_o    (wr_main),
        .wr_aux_o     (wr_aux),
        .resync_o     (resync)
    );

    assign mode = mode_cur;

    // R5: committed mode never holds the invalid code
    a_r5_mode_code: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

endmodule

// File: tb/sim_tape_mode_seq.sv
module sim_tape_mode_seq;
    localparam int SEG = 8;
    localparam int ML  = 2;
    localparam int AL  = 1;
    localparam int RS  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic err_clr = 1'b0;
    logic [1:0] mode, seg;
    logic wr_main, wr_aux, resync, req_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string phase = "R1";

    // reference model state
    int m_cyc, m_seg, m_mode, m_pv, m_pm, m_err, m_wm, m_wa, m_wait, m_ev, m_rs;

    always #2.5 clk = ~clk;

    tape_mode_seq #(.SEG_CYCLES(SEG), .MAIN_LEAD(ML), .AUX_LEAD(AL), .RESYNC_SEGS(RS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .err_clr(err_clr), .mode(mode), .seg(seg), .wr_main(wr_main),
        .wr_aux(wr_aux), .resync(resync), .req_err(req_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%s) at cycle %0d: actual %0d expected %0d", tag, phase, cycles, act, exp);
        end
    endtask

    // Behavioural reference: event-by-event account of the rules.
    always @(posedge clk) begin
        bit last, go, legal, rej;
        int nxt;
        if (!rst_n) begin
            m_cyc = 0; m_seg = 0; m_mode = 0; m_pv = 0; m_pm = 0; m_err = 0;
            m_wm = 0; m_wa = 0; m_wait = 0; m_ev = 0; m_rs = 0;
        end else begin
            last = (m_cyc == SEG - 1);
            go = 0;
            if (m_pv && last) begin
                if (m_mode == 0 && m_pm == 1) go = 1;
                if (m_mode == 0 && m_pm == 2 && m_seg == 2) go = 1;
                if (m_mode != 0 && m_pm == 0 && m_seg == 0) go = 1;
            end
            nxt = go ? m_pm : m_mode;
            legal = req_valid && req_mode != 3 && req_mode != nxt && (nxt == 0 || req_mode == 0);
            rej = req_valid && !legal;
            if (rej) m_err = 1; else if (err_clr) m_err = 0;
            // resync window
            if (go && m_mode == 1) m_rs = RS;
            else if (last && m_rs > 0) m_rs--;
            // writes
            if (go) begin
                m_ev = 0;
                if (m_pm == 0) begin m_wait = 0; m_wm = 0; m_wa = 0; end
                else m_wait = 1;
            end else if (m_wait && last) begin
                if (m_seg == 0 && m_ev >= ((m_mode == 1) ? ML : AL)) begin
                    m_wait = 0; m_wa = 1; m_wm = (m_mode == 1);
                end
                if (m_seg == 3) m_ev++;
            end
            // segment
            if (last) m_seg = (go && m_mode == 1) ? 0 : (m_seg + 1) % 4;
            m_cyc = last ? 0 : m_cyc + 1;
            // pending and mode
            if (legal) begin m_pv = 1; m_pm = req_mode; end
            else if (go) m_pv = 0;
            m_mode = nxt;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(seg == m_seg[1:0], "R2 seg", seg, m_seg);
            chk(mode == m_mode[1:0], "R5/R6/R7 mode", mode, m_mode);
            chk(wr_main == m_wm[0], "R8 wr_main", wr_main, m_wm);
            chk(wr_aux == m_wa[0], "R9/R10 wr_aux", wr_aux, m_wa);
            chk(resync == m_rs > 0, "R12 resync", resync, m_rs > 0);
            chk(req_err == m_err[0], "R3 req_err", req_err, m_err);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ask(input int md);
        req_valid = 1'b1; req_mode = 2'(md);
        tick(1);
        req_valid = 1'b0;
    endtask

    // Go to the first cycle of segment s.
    task automatic seg_start(input int s);
        while (seg == 2'(s)) tick(1);
        while (seg != 2'(s)) tick(1);
    endtask

    initial begin
        int hi;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk(mode == 0 && seg == 0 && !wr_main && !wr_aux && !resync && !req_err,
            "R1 reset", {mode, seg, wr_main, wr_aux, resync, req_err}, 0);

        // R5 corner: request in the last cycle of a segment
        phase = "R5";
        seg_start(1); tick(SEG - 1);
        ask(1);
        tick(2);
        chk(mode == 0, "R5 late request waits", mode, 0);
        tick(SEG);
        chk(mode == 1, "R5 commit", mode, 1);
        // R8: delayed start of main writing
        phase = "R8";
        tick(SEG * 12);
        chk(wr_main && wr_aux, "R8 writing", {wr_main, wr_aux}, 3);

        // R3: illegal requests and sticky error
        phase = "R3";
        ask(2); tick(1);
        chk(req_err == 1 && mode == 1, "R3 rec-to-rec rejected", req_err, 1);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        chk(req_err == 0, "R3 clear", req_err, 0);
        req_valid = 1'b1; req_mode = 2'd1; err_clr = 1'b1; tick(1);
        req_valid = 1'b0; err_clr = 1'b0;
        chk(req_err == 1, "R3 set beats clear", req_err, 1);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;
        ask(3); tick(1);
        chk(req_err == 1, "R3 code 3", req_err, 1);
        err_clr = 1'b1; tick(1); err_clr = 1'b0;

        // R7, R11, R12: full record back to play
        phase = "R12";
        ask(0);
        while (!resync) tick(1);
        chk(mode == 0 && seg == 0 && !wr_main && !wr_aux, "R11 seg forced 0", seg, 0);
        hi = 0;
        while (resync && hi < SEG * 20) begin tick(1); hi++; end
        chk(hi == SEG * RS, "R12 resync length", hi, SEG * RS);

        // R6, R9: play to aux only
        phase = "R6";
        seg_start(0);
        ask(2);
        tick(SEG * 12);
        chk(mode == 2 && wr_aux && !wr_main, "R9 aux only writing", {wr_main, wr_aux}, 1);
        // R10: aux only back to play
        phase = "R10";
        ask(0);
        tick(SEG * 5);
        chk(mode == 0 && !wr_aux && !resync, "R10 stop", wr_aux, 0);

        // R4: replacement of a pending request
        phase = "R4";
        seg_start(0);
        ask(2); ask(1);
        tick(SEG);
        chk(mode == 1, "R4 newer request replaced", mode, 1);
        // R4/R10: request colliding with a commit, before writing starts
        ask(0);
        seg_start(0); tick(SEG - 1);
        ask(1);
        tick(1);
        chk(mode == 0 && !req_err, "R4 judged against new mode", req_err, 0);
        tick(SEG * 2);
        chk(mode == 1, "R4 collided request commits", mode, 1);
        tick(SEG * 14);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (%s): actual %0d expected below %0d", phase, cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule